// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer

This block sits at the register-write edge of a programmable interrupt controller that has only two addresses. It turns a stream of byte writes into a short setup dialogue and then into steady operation. After reset it accepts nothing but the opening setup word. That word is recognised on the low address by a flag in bit 4, and it can restart setup at any time. Two of its bits choose the rest of the dialogue: whether a cascade word follows the vector base, and whether a mode word comes at the end.

Once setup is complete, writes to the high address load the interrupt mask. Writes to the low address are sorted into two classes of operational command. Each class is stored and announced to the interrupt core by a one-cycle pulse. A restart of setup is announced by its own pulse, so that the core can drop its in-service state. A write that makes no sense in the current phase is dropped and flagged with an error pulse. Priority resolution and end-of-interrupt handling belong to the interrupt core, not to this block.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, every stored word and the mask read 0x00, except the stored second-class command, which reads 0x02. `ready` is low and no pulse is active.
- R2: In any phase, a low-address write with bit 4 set stores the setup word, clears the mask, restarts setup and drops `ready`. `init_pulse` is high in the cycle after the write.
- R3: While the block waits for the vector base, a high-address write stores that byte in `vector_base`.
- R4: After the vector base, the block waits for a cascade word when setup-word bit 1 is 0. When bit 1 is 1 and bit 0 is 1, it waits for a mode word. When bit 1 is 1 and bit 0 is 0, it becomes ready.
- R5: After the cascade word, the block waits for a mode word when setup-word bit 0 is 1 and becomes ready when it is 0. After the mode word it always becomes ready. `ready` is high from the cycle after the last setup write.
- R6: While ready, a high-address write loads `irq_mask` and changes no other stored word.
- R7: While ready, a low-address write with bits 4:3 = 00 is stored in `op2_word`, and `op2_pulse` is high for one cycle.
- R8: While ready, a low-address write with bits 4:3 = 01 is stored in `op3_word`, and `op3_pulse` is high for one cycle.
- R9: Before setup completes, a low-address write with bit 4 clear leaves every stored word and the setup phase as they were, and `err_pulse` is high for one cycle.
- R10: While the block waits for the opening setup word, a high-address write is dropped and raises `err_pulse` for one cycle.
- R11: Every pulse lasts exactly one cycle per write, and at most one of the four pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_a0 | input | 1 | Address select: 0 low, 1 high |
| wr_data | input | DW | Write data byte |
| init_word | output | DW | Stored opening setup word |
| vector_base | output | DW | Stored vector base |
| cascade_cfg | output | DW | Stored cascade word |
| mode_cfg | output | DW | Stored mode word |
| irq_mask | output | DW | Interrupt mask |
| op2_word | output | DW | Last first-class operational command |
| op3_word | output | DW | Last second-class operational command |
| ready | output | 1 | Setup complete |
| op2_pulse | output | 1 | First-class command arrived |
| op3_pulse | output | 1 | Second-class command arrived |
| init_pulse | output | 1 | Setup restarted |
| err_pulse | output | 1 | Write dropped |

## Verification
On every cycle, the bound checker covers the pulse exclusivity, the mask and command loads while ready, the effect of a setup restart, and the rejection of out-of-phase low-address writes. The branching of the setup dialogue on the two flag bits is not visible at any single edge. Only the directed scenarios show it: they observe which stored word a later high-address write lands in, and the cycle in which `ready` rises.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_VEC, ST_CAS, ST_MODE, ST_RUN
   } seq_state_e;

   typedef enum logic [3:0] {
      W_NONE, W_INIT, W_VEC, W_CAS, W_MODE, W_MASK, W_OP2, W_OP3, W_BAD
   } wr_kind_e;

   localparam int FLAG_BIT   = 4;
   localparam int CLASS_BIT  = 3;
   localparam int SINGLE_BIT = 1;
   localparam int MODE_BIT   = 0;
endpackage

// File: rtl/pic_wr_classify.sv
module pic_wr_classify
   import pic_init_pkg::*;
(
   input  logic       wr_en,
   input  logic       wr_a0,
   input  logic [1:0] cls_bits,   // data bits 4:3
   input  seq_state_e state,
   output wr_kind_e   kind
);
   always_comb begin
      kind = W_NONE;
      if (wr_en) begin
         if (!wr_a0) begin
            if (cls_bits[1])          kind = W_INIT;
            else if (state == ST_RUN) kind = cls_bits[0] ? W_OP3 : W_OP2;
            else                      kind = W_BAD;
         end else begin
            unique case (state)
               ST_IDLE: kind = W_BAD;
               ST_VEC:  kind = W_VEC;
               ST_CAS:  kind = W_CAS;
               ST_MODE: kind = W_MODE;
               ST_RUN:  kind = W_MASK;
               default: kind = W_BAD;
            endcase
         end
      end
   end
endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
   import pic_init_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wr_kind_e   kind,
   input  logic [1:0] flags,      // {single, mode-word-follows} of setup word
   output seq_state_e state,
   output logic       ready
);
   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (kind)
         W_INIT: nxt = ST_VEC;
         W_VEC:  nxt = !flags[1] ? ST_CAS : (flags[0] ? ST_MODE : ST_RUN);
         W_CAS:  nxt = flags[0] ? ST_MODE : ST_RUN;
         W_MODE: nxt = ST_RUN;
         default: nxt = state;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign ready = (state == ST_RUN);
endmodule

// File: rtl/pic_cfg_bank.sv
module pic_cfg_bank
   import pic_init_pkg::*;
#(
   parameter int          DW      = 8,
   parameter logic [DW-1:0] OP3_RST = DW'(8'h02)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wr_kind_e      kind,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] init_word,
   output logic [DW-1:0] vector_base,
   output logic [DW-1:0] cascade_cfg,
   output logic [DW-1:0] mode_cfg,
   output logic [DW-1:0] irq_mask,
   output logic [DW-1:0] op2_word,
   output logic [DW-1:0] op3_word,
   output logic          op2_pulse,
   output logic          op3_pulse,
   output logic          init_pulse,
   output logic          err_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_word   <= '0;
         vector_base <= '0;
         cascade_cfg <= '0;
         mode_cfg    <= '0;
         irq_mask    <= '0;
         op2_word    <= '0;
         op3_word    <= OP3_RST;
         op2_pulse   <= 1'b0;
         op3_pulse   <= 1'b0;
         init_pulse  <= 1'b0;
         err_pulse   <= 1'b0;
      end else begin
         op2_pulse  <= 1'b0;
         op3_pulse  <= 1'b0;
         init_pulse <= 1'b0;
         err_pulse  <= 1'b0;
         unique case (kind)
            W_INIT: begin
               init_word  <= din;
               irq_mask   <= '0;
               init_pulse <= 1'b1;
            end
            W_VEC:  vector_base <= din;
            W_CAS:  cascade_cfg <= din;
            W_MODE: mode_cfg    <= din;
            W_MASK: irq_mask    <= din;
            W_OP2: begin
               op2_word  <= din;
               op2_pulse <= 1'b1;
            end
            W_OP3: begin
               op3_word  <= din;
               op3_pulse <= 1'b1;
            end
            W_BAD:  err_pulse <= 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_init_pkg::*;
#(
   parameter int            DW      = 8,
   parameter logic [DW-1:0] OP3_RST = DW'(8'h02)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_a0,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] init_word,
   output logic [DW-1:0] vector_base,
   output logic [DW-1:0] cascade_cfg,
   output logic [DW-1:0] mode_cfg,
   output logic [DW-1:0] irq_mask,
   output logic [DW-1:0] op2_word,
   output logic [DW-1:0] op3_word,
   output logic          ready,
   output logic          op2_pulse,
   output logic          op3_pulse,
   output logic          init_pulse,
   output logic          err_pulse
);
   localparam int MIN_DW = FLAG_BIT + 1;

   generate
      if (DW < MIN_DW) begin : g_dw_chk
         $error("pic_init_seq: DW must cover the class flag bits");
      end
   endgenerate

   seq_state_e state;
   wr_kind_e   kind;

   pic_wr_classify u_cls (
      .wr_en    (wr_en),
      .wr_a0    (wr_a0),
      .cls_bits (wr_data[FLAG_BIT:CLASS_BIT]),
      .state    (state),
      .kind     (kind)
   );

   pic_seq_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .flags ({init_word[SINGLE_BIT], init_word[MODE_BIT]}),
      .state (state),
      .ready (ready)
   );

   pic_cfg_bank #(.DW(DW), .OP3_RST(OP3_RST)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind        (kind),
      .din         (wr_data),
      .init_word   (init_word),
      .vector_base (vector_base),
      .cascade_cfg (cascade_cfg),
      .mode_cfg    (mode_cfg),
      .irq_mask    (irq_mask),
      .op2_word    (op2_word),
      .op3_word    (op3_word),
      .op2_pulse   (op2_pulse),
      .op3_pulse   (op3_pulse),
      .init_pulse  (init_pulse),
      .err_pulse   (err_pulse)
   );
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          wr_a0,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] init_word,
   input logic [DW-1:0] irq_mask,
   input logic [DW-1:0] op2_word,
   input logic [DW-1:0] op3_word,
   input logic          ready,
   input logic          op2_pulse,
   input logic          op3_pulse,
   input logic          init_pulse,
   input logic          err_pulse
);
   // R11
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op2_pulse, op3_pulse, init_pulse, err_pulse}));

   // R2
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_a0 && wr_data[4]) |=>
         (init_pulse && !ready && irq_mask == '0 && init_word == $past(wr_data)));

   // R6
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_a0 && ready) |=>
         (irq_mask == $past(wr_data) && ready && $stable(init_word)));

   // R7
   op2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_a0 && ready && wr_data[4:3] == 2'b00) |=>
         (op2_pulse && op2_word == $past(wr_data) && $stable(op3_word)));

   // R8
   op3_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_a0 && ready && wr_data[4:3] == 2'b01) |=>
         (op3_pulse && op3_word == $past(wr_data) && $stable(op2_word)));

   // R9
   early_op_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_a0 && !ready && !wr_data[4]) |=>
         (err_pulse && !ready && $stable(init_word) && $stable(irq_mask)));

   // R11
   no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !(op2_pulse || op3_pulse || init_pulse || err_pulse));
endmodule

bind pic_init_seq pic_init_seq_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_a0      (wr_a0),
   .wr_data    (wr_data),
   .init_word  (init_word),
   .irq_mask   (irq_mask),
   .op2_word   (op2_word),
   .op3_word   (op3_word),
   .ready      (ready),
   .op2_pulse  (op2_pulse),
   .op3_pulse  (op3_pulse),
   .init_pulse (init_pulse),
   .err_pulse  (err_pulse)
);

// File: tb/pic_init_seq_test.sv
module pic_init_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_a0 = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] init_word, vector_base, cascade_cfg, mode_cfg, irq_mask, op2_word, op3_word;
   logic       ready, op2_pulse, op3_pulse, init_pulse, err_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pic_init_seq uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
      .init_word(init_word), .vector_base(vector_base), .cascade_cfg(cascade_cfg),
      .mode_cfg(mode_cfg), .irq_mask(irq_mask), .op2_word(op2_word), .op3_word(op3_word),
      .ready(ready), .op2_pulse(op2_pulse), .op3_pulse(op3_pulse),
      .init_pulse(init_pulse), .err_pulse(err_pulse)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pulses();
      return {4'b0, op2_pulse, op3_pulse, init_pulse, err_pulse};
   endfunction

   // drive at a falling edge, captured at the next rising edge,
   // returns at the following falling edge with outputs updated
   task automatic wr(input logic a0, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_a0 = a0; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 init_word", init_word, 8'h00);
      chk("R1 vector", vector_base, 8'h00);
      chk("R1 cascade", cascade_cfg, 8'h00);
      chk("R1 mode", mode_cfg, 8'h00);
      chk("R1 mask", irq_mask, 8'h00);
      chk("R1 op2", op2_word, 8'h00);
      chk("R1 op3", op3_word, 8'h02);
      chk("R1 ready", {7'b0, ready}, 8'h00);
      chk("R1 pulses", pulses(), 8'h00);
   endtask

   task automatic t_full_cascade();
      wr(1'b0, 8'h11);
      chk("R2 init_word", init_word, 8'h11);
      chk("R2 init pulse", pulses(), 8'h02);
      chk("R2 ready low", {7'b0, ready}, 8'h00);
      @(negedge clk);
      chk("R11 pulse ends", pulses(), 8'h00);
      wr(1'b1, 8'h20);
      chk("R3 vector", vector_base, 8'h20);
      chk("R4 not ready", {7'b0, ready}, 8'h00);
      wr(1'b1, 8'h04);
      chk("R4 cascade taken", cascade_cfg, 8'h04);
      chk("R4 mode untouched", mode_cfg, 8'h00);
      wr(1'b1, 8'h01);
      chk("R5 mode", mode_cfg, 8'h01);
      chk("R5 ready", {7'b0, ready}, 8'h01);
      wr(1'b1, 8'hA5);
      chk("R6 mask", irq_mask, 8'hA5);
      chk("R6 vector kept", vector_base, 8'h20);
   endtask

   task automatic t_single_mode();
      wr(1'b0, 8'h13);
      chk("R2 restart mask clear", irq_mask, 8'h00);
      chk("R2 restart ready low", {7'b0, ready}, 8'h00);
      wr(1'b1, 8'h30);
      chk("R3 vector", vector_base, 8'h30);
      wr(1'b1, 8'h5A);
      chk("R4 skip cascade", cascade_cfg, 8'h04);
      chk("R4 mode word", mode_cfg, 8'h5A);
      chk("R5 ready after mode", {7'b0, ready}, 8'h01);
   endtask

   task automatic t_single_nomode();
      wr(1'b0, 8'h12);
      wr(1'b1, 8'h40);
      chk("R4 ready after vector", {7'b0, ready}, 8'h01);
      wr(1'b1, 8'h0F);
      chk("R6 mask", irq_mask, 8'h0F);
      chk("R6 mode kept", mode_cfg, 8'h5A);
   endtask

   task automatic t_cascade_nomode();
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h50);
      chk("R4 waits cascade", {7'b0, ready}, 8'h00);
      wr(1'b1, 8'h02);
      chk("R5 cascade", cascade_cfg, 8'h02);
      chk("R5 ready", {7'b0, ready}, 8'h01);
      chk("R5 mode kept", mode_cfg, 8'h5A);
   endtask

   task automatic t_ops();
      wr(1'b1, 8'h3C);
      wr(1'b0, 8'h20);
      chk("R7 op2", op2_word, 8'h20);
      chk("R7 pulse", pulses(), 8'h08);
      wr(1'b0, 8'h0B);
      chk("R8 op3", op3_word, 8'h0B);
      chk("R8 pulse", pulses(), 8'h04);
      chk("R8 op2 kept", op2_word, 8'h20);
      chk("R7 mask kept", irq_mask, 8'h3C);
      @(negedge clk);
      chk("R11 pulse ends", pulses(), 8'h00);
   endtask

   task automatic t_bad_during_setup();
      wr(1'b0, 8'h11);
      wr(1'b0, 8'h08);
      chk("R9 err pulse", pulses(), 8'h01);
      chk("R9 init kept", init_word, 8'h11);
      chk("R9 op3 kept", op3_word, 8'h0B);
      wr(1'b1, 8'h60);
      chk("R9 phase kept", vector_base, 8'h60);
      chk("R9 still setup", {7'b0, ready}, 8'h00);
   endtask

   task automatic t_bad_idle();
      do_reset();
      wr(1'b1, 8'h77);
      chk("R10 err pulse", pulses(), 8'h01);
      chk("R10 mask kept", irq_mask, 8'h00);
      chk("R10 vector kept", vector_base, 8'h00);
      wr(1'b0, 8'h08);
      chk("R9 idle err", pulses(), 8'h01);
      chk("R9 op3 kept", op3_word, 8'h02);
      wr(1'b0, 8'h12);
      wr(1'b1, 8'h90);
      chk("R3 after idle errors", vector_base, 8'h90);
   endtask

   initial begin
      t_reset();
      t_full_cascade();
      t_single_mode();
      t_single_nomode();
      t_cascade_nomode();
      t_ops();
      t_bad_during_setup();
      t_bad_idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule